// File: doc/BRIEF.md
# Synchronous buck gate-drive sequencer

This block is the digital control core of a half-bridge gate driver for one phase of a synchronous buck converter. External comparators resolve the PWM command into a high, low or mid level before it arrives here. The sequencer turns that level into high-side and low-side gate enables. It enforces break-before-make, using a fixed minimum dead time and the sensed gate-low indications of both switches. A mid-level command must persist for a hold-off interval before both switches are released.

Two conduction modes are available for the PWM low interval. The mode input selects between them. In forced continuous conduction, the low-side stays on for the whole low interval. In diode emulation, a zero-current comparator ends low-side conduction once a blanking interval has passed. A supply-good flag gates both outputs combinationally. A floating mode input combined with a held mid-level command parks the block in a shutdown state. The current sequencer state is reported on a debug output.

Top module: `buck_gate_seq`

## Requirements
- R1: When the PWM level changes between high and low, the conducting gate turns off first. Both gates then stay off for at least DEAD_CYC clock cycles before the other gate turns on. With DEAD_CYC=2 and the sense input already low, the new gate is on in the third cycle after the level change.
- R2: The high-side is turned on only while the low-side sense input `ls_low_i` is 1. The low-side is turned on only while the high-side sense input `hs_low_i` is 1. While the required sense bit is 0, the block waits in the dead-time state.
- R3: `pwm_lvl_i` encodes 2'b00 as low, 2'b01 as high, and 2'b1x as mid level. When the mid level is held for HOLD_CYC consecutive cycles, both gates turn off and the state becomes tri-state. With HOLD_CYC=8, this takes effect at the eighth cycle. A mid excursion of HOLD_CYC-1 cycles or fewer leaves the outputs unchanged.
- R4: With `ccm_force_i`=0 (diode emulation), the low-side turns on after the normal dead time. `zc_i` is ignored during the first BLANK_CYC cycles of low-side conduction.
- R5: In diode emulation, once blanking has elapsed, `zc_i`=1 turns the low-side off and moves the state to off. The low-side then stays off, even with PWM still low, until PWM goes high.
- R6: With `ccm_force_i`=1, the low-side stays on for the whole PWM low interval whatever the value of `zc_i`.
- R7: The tri-state and shutdown states are left only on a valid high or low PWM level. The exit passes through the dead-time state.
- R8: While `supply_ok_i`=0, both gate outputs are 0 in the same cycle. The state becomes UVLO at the next clock edge. When supply returns, the block passes through off and then restarts through the normal sequence.
- R9: When the mid level completes its hold-off while `ccm_float_i`=1, the block enters the shutdown state with both gates off.
- R10: `state_o` encodes the states as follows: off=0, high-side on=1, low-side on=2, dead time=3, tri-state=4, UVLO=5, shutdown=6. The reset state is UVLO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_lvl_i | input | 2 | Resolved PWM level: 00 low, 01 high, 1x mid |
| ccm_force_i | input | 1 | 1 forces continuous conduction, 0 allows diode emulation |
| ccm_float_i | input | 1 | Mode input detected as floating |
| zc_i | input | 1 | Zero-current comparator output |
| hs_low_i | input | 1 | High-side gate sensed below its low threshold |
| ls_low_i | input | 1 | Low-side gate sensed below its low threshold |
| supply_ok_i | input | 1 | Supply above the lockout threshold |
| hs_on_o | output | 1 | High-side gate enable |
| ls_on_o | output | 1 | Low-side gate enable |
| state_o | output | 3 | Debug state code |

## Verification
The PWM level is driven through low-to-high and high-to-low edges to show dead-time length and turn-on order. The same edges are repeated with a sense bit held at 0, which separates the fixed delay from the sensed wait. Mid-level pulses one cycle shorter than the hold-off and exactly as long as it distinguish a filtered glitch from a real release. A held mid level with the mode input floating tells shutdown apart from tri-state. Low intervals with the zero-current input held at 1 are run in both conduction modes, which separates the blanking window, the diode-emulation turn-off and forced conduction. Supply drops taken mid-conduction show the same-cycle gating and the restart path.

// File: rtl/gsq_pkg.sv
package gsq_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_HS   = 3'd1,
    ST_LS   = 3'd2,
    ST_DEAD = 3'd3,
    ST_TRI  = 3'd4,
    ST_UVLO = 3'd5,
    ST_SHDN = 3'd6
  } gsq_state_e;

  typedef struct packed {
    logic hi;
    logic lo;
    logic mid;
  } gsq_pwm_t;
endpackage

// File: rtl/gsq_pwm_decode.sv
module gsq_pwm_decode
  import gsq_pkg::*;
(
  input  logic [1:0] pwm_lvl_i,
  output gsq_pwm_t   pwm_o
);
  always_comb begin
    pwm_o.mid = pwm_lvl_i[1];
    pwm_o.hi  = ~pwm_lvl_i[1] &  pwm_lvl_i[0];
    pwm_o.lo  = ~pwm_lvl_i[1] & ~pwm_lvl_i[0];
  end
endmodule

// File: rtl/gsq_delay_cnt.sv
// Counts consecutive enabled cycles; done on the LIMIT-th one, then saturates.
module gsq_delay_cnt #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic done_o
);
  localparam int unsigned CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
  import gsq_pkg::*;
#(
  parameter int unsigned HOLD_CYC  = 8,
  parameter int unsigned DEAD_CYC  = 2,
  parameter int unsigned BLANK_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] pwm_lvl_i,
  input  logic       ccm_force_i,
  input  logic       ccm_float_i,
  input  logic       zc_i,
  input  logic       hs_low_i,
  input  logic       ls_low_i,
  input  logic       supply_ok_i,
  output logic       hs_on_o,
  output logic       ls_on_o,
  output logic [2:0] state_o
);
  gsq_state_e st_q, st_d;
  logic       tgt_hs_q, tgt_hs_d;
  logic       park_q, park_d;
  gsq_pwm_t   pwm;
  logic       mid_done, dead_done, blank_done;
  gsq_state_e idle_st;

  gsq_pwm_decode u_dec (.pwm_lvl_i(pwm_lvl_i), .pwm_o(pwm));

  gsq_delay_cnt #(.LIMIT(HOLD_CYC)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(pwm.mid), .done_o(mid_done));

  gsq_delay_cnt #(.LIMIT(DEAD_CYC)) u_dead (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(st_q == ST_DEAD), .done_o(dead_done));

  gsq_delay_cnt #(.LIMIT(BLANK_CYC)) u_blank (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(st_q == ST_LS), .done_o(blank_done));

  assign idle_st = ccm_float_i ? ST_SHDN : ST_TRI;

  always_comb begin
    st_d     = st_q;
    tgt_hs_d = tgt_hs_q;
    park_d   = park_q;
    if (!supply_ok_i) begin
      st_d   = ST_UVLO;
      park_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_UVLO: st_d = ST_OFF;
        ST_OFF: begin
          if (pwm.hi) begin
            st_d = ST_DEAD; tgt_hs_d = 1'b1; park_d = 1'b0;
          end else if (pwm.lo && !park_q) begin
            st_d = ST_DEAD; tgt_hs_d = 1'b0;
          end else if (mid_done) begin
            st_d = idle_st; park_d = 1'b0;
          end
        end
        ST_DEAD: begin
          if (pwm.hi)      tgt_hs_d = 1'b1;
          else if (pwm.lo) tgt_hs_d = 1'b0;
          if (mid_done) st_d = idle_st;
          else if (dead_done) begin
            if (tgt_hs_d && ls_low_i)        st_d = ST_HS;
            else if (!tgt_hs_d && hs_low_i)  st_d = ST_LS;
          end
        end
        ST_HS: begin
          if (pwm.lo) begin
            st_d = ST_DEAD; tgt_hs_d = 1'b0;
          end else if (mid_done) st_d = idle_st;
        end
        ST_LS: begin
          if (pwm.hi) begin
            st_d = ST_DEAD; tgt_hs_d = 1'b1;
          end else if (mid_done) st_d = idle_st;
          else if (!ccm_force_i && blank_done && zc_i) begin
            st_d = ST_OFF; park_d = 1'b1;
          end
        end
        ST_TRI: begin
          if (ccm_float_i) st_d = ST_SHDN;
          else if (pwm.hi) begin
            st_d = ST_DEAD; tgt_hs_d = 1'b1;
          end else if (pwm.lo) begin
            st_d = ST_DEAD; tgt_hs_d = 1'b0;
          end
        end
        ST_SHDN: begin
          if (pwm.hi) begin
            st_d = ST_DEAD; tgt_hs_d = 1'b1;
          end else if (pwm.lo) begin
            st_d = ST_DEAD; tgt_hs_d = 1'b0;
          end
        end
        default: st_d = ST_UVLO;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_UVLO;
      tgt_hs_q <= 1'b0;
      park_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      tgt_hs_q <= tgt_hs_d;
      park_q   <= park_d;
    end
  end

  // supply gating is combinational so a lockout removes drive at once
  assign hs_on_o = (st_q == ST_HS) && supply_ok_i;
  assign ls_on_o = (st_q == ST_LS) && supply_ok_i;
  assign state_o = st_q;
endmodule

// File: rtl/buck_gate_seq_chk.sv
module buck_gate_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       supply_ok_i,
  input logic       hs_low_i,
  input logic       ls_low_i,
  input logic       hs_on_o,
  input logic       ls_on_o,
  input logic [2:0] state_o
);
  a_r1_bbm_hs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_on_o) |-> $past(!ls_on_o));
  a_r1_bbm_ls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_on_o) |-> $past(!hs_on_o));
  a_r1_dead_before_hs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_on_o) |-> $past(state_o == 3'd3));
  a_r2_sense_hs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_on_o) |-> $past(ls_low_i));
  a_r2_sense_ls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_on_o) |-> $past(hs_low_i));
  a_r8_uvlo_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (state_o == 3'd5));
endmodule

bind buck_gate_seq buck_gate_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .supply_ok_i(supply_ok_i),
  .hs_low_i(hs_low_i), .ls_low_i(ls_low_i),
  .hs_on_o(hs_on_o), .ls_on_o(ls_on_o), .state_o(state_o));

// File: tb/tb_buck_gate_seq.sv
module tb_buck_gate_seq;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pwm = 2'b00;
  logic       ccm_force = 1'b1;
  logic       ccm_float = 1'b0;
  logic       zc = 1'b0;
  logic       hs_low = 1'b1;
  logic       ls_low = 1'b1;
  logic       sup_ok = 1'b1;
  logic       hs_on, ls_on;
  logic [2:0] state;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [1:0] P_LO = 2'b00, P_HI = 2'b01, P_MID = 2'b10;

  always #(CLK_PERIOD/2) clk = ~clk;

  buck_gate_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .pwm_lvl_i(pwm), .ccm_force_i(ccm_force),
    .ccm_float_i(ccm_float), .zc_i(zc), .hs_low_i(hs_low), .ls_low_i(ls_low),
    .supply_ok_i(sup_ok), .hs_on_o(hs_on), .ls_on_o(ls_on), .state_o(state));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_high();  // R1
    pwm = P_HI; cyc(2);
    chk("R1 hs off in dead", hs_on, 0);
    chk("R1 ls off in dead", ls_on, 0);
    chk("R10 dead code", state, 3);
    cyc(1);
    chk("R1 hs on", hs_on, 1);
    chk("R10 hs code", state, 1);
  endtask

  task automatic go_low();  // R1
    pwm = P_LO; cyc(2);
    chk("R1 both off before ls", hs_on | ls_on, 0);
    cyc(1);
    chk("R1 ls on", ls_on, 1);
    chk("R10 ls code", state, 2);
  endtask

  task automatic t_reset();  // R10
    cyc(2);
    chk("R10 reset state uvlo", state, 5);
    chk("R8 reset outputs", hs_on | ls_on, 0);
    rst_n = 1'b1; cyc(1);
    chk("R10 off code", state, 0);
    cyc(2);
    chk("R1 dead after reset", state, 3);
    cyc(1);
    chk("R1 ls on after reset", ls_on, 1);
  endtask

  task automatic t_sense();  // R2
    go_high();
    hs_low = 1'b0; pwm = P_LO; cyc(6);
    chk("R2 waits on hs sense", ls_on, 0);
    chk("R2 dead state held", state, 3);
    hs_low = 1'b1; cyc(1);
    chk("R2 ls on after sense", ls_on, 1);
    ls_low = 1'b0; pwm = P_HI; cyc(6);
    chk("R2 waits on ls sense", hs_on, 0);
    ls_low = 1'b1; cyc(1);
    chk("R2 hs on after sense", hs_on, 1);
    go_low();
  endtask

  task automatic t_tri();  // R3 R7
    pwm = P_MID; cyc(7);
    chk("R3 short mid ignored", ls_on, 1);
    pwm = P_LO; cyc(3);
    chk("R3 ls kept after glitch", ls_on, 1);
    pwm = P_MID; cyc(7);
    chk("R3 ls before hold end", ls_on, 1);
    cyc(1);
    chk("R3 ls off at hold end", ls_on, 0);
    chk("R3 tri code", state, 4);
    cyc(5);
    chk("R7 tri held on mid", state, 4);
    go_high();
  endtask

  task automatic t_de();  // R4 R5
    ccm_force = 1'b0; zc = 1'b1;
    pwm = P_LO; cyc(6);
    chk("R4 zc blanked", ls_on, 1);
    cyc(1);
    chk("R5 zc turns ls off", ls_on, 0);
    chk("R5 off code", state, 0);
    cyc(6);
    chk("R5 ls stays off on low", ls_on, 0);
    zc = 1'b0;
    go_high();
  endtask

  task automatic t_ccm();  // R6
    ccm_force = 1'b1; zc = 1'b1;
    go_low();
    cyc(20);
    chk("R6 ccm ls kept", ls_on, 1);
    zc = 1'b0;
    go_high();
  endtask

  task automatic t_uvlo();  // R8
    sup_ok = 1'b0; #1;
    chk("R8 hs dropped at once", hs_on, 0);
    cyc(1);
    chk("R8 uvlo code", state, 5);
    sup_ok = 1'b1; cyc(1);
    chk("R8 off after uvlo", state, 0);
    cyc(2);
    chk("R8 dead on restart", state, 3);
    cyc(1);
    chk("R8 hs back", hs_on, 1);
  endtask

  task automatic t_shdn();  // R9 R7
    ccm_float = 1'b1; pwm = P_MID; cyc(8);
    chk("R9 shutdown code", state, 6);
    chk("R9 gates off", hs_on | ls_on, 0);
    ccm_float = 1'b0; pwm = P_LO; cyc(2);
    chk("R7 exit via dead", state, 3);
    cyc(1);
    chk("R7 ls on after exit", ls_on, 1);
  endtask

  initial begin
    t_reset();
    t_sense();
    t_tri();
    t_de();
    t_ccm();
    t_uvlo();
    t_shdn();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule